// File: doc/BRIEF.md
# Dispatch and In-Order Retire Controller

This block sits between an in-order queue of decoded instructions and a set of downstream schedulers. Each cycle it looks at up to `DISP_W` instructions at the head of the queue. Each instruction carries a micro-op count, a flag for a destination register, load and store flags, and a scheduler index. The block admits the longest prefix of those instructions that fits every resource. The resources are the group width in micro-ops, free reorder-buffer slots (also counted in micro-ops), free physical registers, the target scheduler queue, and the load and store queues. Each admitted instruction receives a reorder-buffer tag.

A tagged write-back strobe marks an entry complete. Entries retire strictly from the oldest, up to `RET_W` per cycle. Retirement returns the entry's reorder-buffer slots and its physical register. Scheduler queue occupancy is tracked as credits: a dispatch takes a credit and an issue pulse from the scheduler returns it.

For performance analysis the block keeps one counter per stall cause. It also keeps two histograms: one of micro-ops dispatched per cycle and one of instructions retired per cycle.

Top module: `dispatch_retire_ctrl`

## Requirements
- R1: Dispatch is in program order. `disp_valid` is always a prefix of `in_valid`. Once a slot cannot go, no later slot goes in that cycle, even if that later slot's own resources are free.
- R2: A slot joins the group only if the group's micro-op total including that slot stays at or below `DISP_W`. A slot held back only by this width limit is not counted as a stall.
- R3: `rob_used` is the number of occupied reorder-buffer slots in micro-ops. An instruction with k micro-ops dispatches only when `rob_used` plus the group's micro-ops plus k is no more than `ROB_SLOTS`.
- R4: An instruction with `in_dst` set needs a free physical register. `free_regs` starts at `PREG_POOL`. With `PREG_POOL` = 0 the pool is unlimited and registers never cause a stall.
- R5: Each scheduler queue holds `SCHED_DEPTH` entries. An instruction stalls when its target's occupancy plus the earlier slots of the same group sent to that target reaches `SCHED_DEPTH`. A `sched_issue` pulse frees one entry, visible the next cycle.
- R6: A load stalls while `lq_full` is high and a store stalls while `sq_full` is high. Other instructions are not affected by either flag.
- R7: When the first held slot is blocked by a resource, exactly one entry of `stall_cnt` increments that cycle. The index is 0 for the reorder buffer, 1 for registers, 2 for the scheduler, 3 for the load queue and 4 for the store queue. When several causes apply, the lowest index wins.
- R8: `wb_valid` with `wb_tag` marks that entry complete from the next cycle. `ret_count` is the number of consecutive complete entries starting from the oldest, capped at `RET_W`.
- R9: Retired slots and registers become free in the cycle after retirement.
- R10: After reset, tags are handed out as consecutive reorder-buffer indices starting at 0 and wrapping modulo `ROB_SLOTS`. Slot i of a group gets the tail index plus i.
- R11: Every cycle, `disp_hist[n]` increments where n is the number of micro-ops dispatched. Likewise `ret_hist[n]` increments where n is the number of instructions retired.
- R12: Synchronous reset empties the reorder buffer and the scheduler credits, refills the register pool, and clears all counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | DISP_W | Queue slot holds an instruction (slot 0 oldest) |
| in_uops | input | DISP_W x UOP_W | Micro-op count per slot, 1..DISP_W |
| in_dst | input | DISP_W | Slot needs a physical register |
| in_ld | input | DISP_W | Slot is a load |
| in_st | input | DISP_W | Slot is a store |
| in_sched | input | DISP_W x SEL_W | Target scheduler per slot |
| sched_issue | input | NUM_SCHED | Scheduler released one entry |
| lq_full | input | 1 | Load queue full |
| sq_full | input | 1 | Store queue full |
| wb_valid | input | 1 | Write-back strobe |
| wb_tag | input | TAG_W | Tag of the completed entry |
| disp_valid | output | DISP_W | Slot dispatched this cycle |
| disp_tag | output | DISP_W x TAG_W | Tag given to each slot |
| ret_count | output | RCW | Instructions retiring this cycle |
| rob_used | output | RBW | Occupied reorder-buffer slots |
| free_regs | output | PBW | Free physical registers |
| stall_cnt | output | 5 x CNT_W | Stall cycles per cause |
| disp_hist | output | (DISP_W+1) x CNT_W | Cycles per dispatched micro-op count |
| ret_hist | output | (RET_W+1) x CNT_W | Cycles per retired instruction count |

## Verification
A drifting micro-op occupancy counter shows up at `rob_used` in the next cycle. It then shows up as a missing or extra `disp_valid` once the buffer nears capacity. A lost register or scheduler credit shows as a stall, counted under the wrong or an extra cause, on the first request that reaches the boundary. A head pointer that skips or a completion flag that sticks produces a wrong `ret_count` in the cycle after the write-back. Such a fault also skews `ret_hist` for good. For this reason the bench fills each resource exactly to its limit and checks both sides of the boundary.

// File: rtl/dr_pkg.sv
package dr_pkg;

    localparam int NUM_CAUSES = 5;

    typedef enum logic [2:0] {
        CAUSE_ROB   = 3'd0,
        CAUSE_REG   = 3'd1,
        CAUSE_SCHED = 3'd2,
        CAUSE_LOAD  = 3'd3,
        CAUSE_STORE = 3'd4,
        CAUSE_NONE  = 3'd7
    } stall_cause_e;

    typedef struct packed {
        logic done;
        logic has_dst;
    } rob_flags_t;

    // bits needed to hold values 0..n-1
    function automatic int bits_for(input int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

endpackage

// File: rtl/dr_group_sel.sv
module dr_group_sel import dr_pkg::*; #(
    parameter int DW   = 2,
    parameter int NS   = 2,
    parameter int SQD  = 4,
    parameter int ROBS = 8,
    parameter int PRF  = 4,
    localparam int UW  = bits_for(DW + 1),
    localparam int SW  = bits_for(NS),
    localparam int IW  = bits_for(ROBS),
    localparam int RBW = bits_for(ROBS + 1),
    localparam int PBW = bits_for(PRF + 1),
    localparam int QBW = bits_for(SQD + 1)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [DW-1:0]           in_valid,
    input  logic [DW-1:0][UW-1:0]   in_uops,
    input  logic [DW-1:0]           in_dst,
    input  logic [DW-1:0]           in_ld,
    input  logic [DW-1:0]           in_st,
    input  logic [DW-1:0][SW-1:0]   in_sched,
    input  logic                    lq_full,
    input  logic                    sq_full,
    input  logic [RBW-1:0]          rob_used,
    input  logic [PBW-1:0]          free_regs,
    input  logic [NS-1:0][QBW-1:0]  sched_occ,
    input  logic [IW-1:0]           rob_tail,
    output logic [DW-1:0]           take,
    output logic [DW-1:0][IW-1:0]   tag,
    output logic [UW-1:0]           grp_dst,
    output logic [NS-1:0][UW-1:0]   sched_add,
    output stall_cause_e            cause
);

    always_comb begin
        int   uacc;
        int   dacc;
        int   sacc [NS];
        logic stop;
        uacc  = 0;
        dacc  = 0;
        stop  = 1'b0;
        take  = '0;
        cause = CAUSE_NONE;
        for (int s = 0; s < NS; s++) sacc[s] = 0;
        for (int i = 0; i < DW; i++) begin
            tag[i] = rob_tail + IW'(i);
            if (!stop) begin
                if (!in_valid[i] || (uacc + int'(in_uops[i]) > DW)) begin
                    stop = 1'b1;
                end else if (int'(rob_used) + uacc + int'(in_uops[i]) > ROBS) begin
                    stop = 1'b1; cause = CAUSE_ROB;
                end else if ((PRF != 0) && in_dst[i] && (int'(free_regs) <= dacc)) begin
                    stop = 1'b1; cause = CAUSE_REG;
                end else if (int'(sched_occ[in_sched[i]]) + sacc[in_sched[i]] >= SQD) begin
                    stop = 1'b1; cause = CAUSE_SCHED;
                end else if (in_ld[i] && lq_full) begin
                    stop = 1'b1; cause = CAUSE_LOAD;
                end else if (in_st[i] && sq_full) begin
                    stop = 1'b1; cause = CAUSE_STORE;
                end else begin
                    take[i] = 1'b1;
                    uacc = uacc + int'(in_uops[i]);
                    dacc = dacc + int'(in_dst[i]);
                    sacc[in_sched[i]] = sacc[in_sched[i]] + 1;
                end
            end
        end
        grp_dst = UW'(dacc);
        for (int s = 0; s < NS; s++) sched_add[s] = UW'(sacc[s]);
    end

    generate
        for (genvar g = 1; g < DW; g++) begin : g_order
            AST_IN_ORDER: assert property (@(posedge clk) disable iff (rst)
                take[g] |-> (take[g-1] && in_valid[g-1])); // R1
        end
    endgenerate

endmodule

// File: rtl/dr_rob.sv
module dr_rob import dr_pkg::*; #(
    parameter int DW   = 2,
    parameter int RW   = 2,
    parameter int ROBS = 8,
    localparam int UW  = bits_for(DW + 1),
    localparam int IW  = bits_for(ROBS),
    localparam int RBW = bits_for(ROBS + 1),
    localparam int RCW = bits_for(RW + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [DW-1:0]         alloc,
    input  logic [DW-1:0][UW-1:0] alloc_uops,
    input  logic [DW-1:0]         alloc_dst,
    input  logic                  wb_valid,
    input  logic [IW-1:0]         wb_tag,
    output logic [IW-1:0]         tail,
    output logic [RBW-1:0]        used,
    output logic [RCW-1:0]        ret_cnt,
    output logic [RCW-1:0]        ret_dst
);

    logic [IW-1:0]  head_q, tail_q;
    logic [RBW-1:0] cnt_q, used_q;
    rob_flags_t     flags_q [ROBS];
    logic [UW-1:0]  uops_q  [ROBS];

    int ret_n_c, ret_u_c, alloc_n_c, alloc_u_c;

    always_comb begin
        int            rd;
        logic          stop;
        logic [IW-1:0] idx;
        ret_n_c = 0;
        ret_u_c = 0;
        rd      = 0;
        stop    = 1'b0;
        for (int r = 0; r < RW; r++) begin
            idx = head_q + IW'(r);
            if (!stop && (r < int'(cnt_q)) && flags_q[idx].done) begin
                ret_n_c = ret_n_c + 1;
                ret_u_c = ret_u_c + int'(uops_q[idx]);
                rd      = rd + int'(flags_q[idx].has_dst);
            end else begin
                stop = 1'b1;
            end
        end
        alloc_n_c = 0;
        alloc_u_c = 0;
        for (int i = 0; i < DW; i++) begin
            if (alloc[i]) begin
                alloc_n_c = alloc_n_c + 1;
                alloc_u_c = alloc_u_c + int'(alloc_uops[i]);
            end
        end
        ret_cnt = RCW'(ret_n_c);
        ret_dst = RCW'(rd);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
            used_q <= '0;
            for (int k = 0; k < ROBS; k++) flags_q[k] <= '0;
        end else begin
            for (int i = 0; i < DW; i++) begin
                if (alloc[i]) begin
                    flags_q[tail_q + IW'(i)] <= '{done: 1'b0, has_dst: alloc_dst[i]};
                    uops_q[tail_q + IW'(i)]  <= alloc_uops[i];
                end
            end
            if (wb_valid) flags_q[wb_tag].done <= 1'b1;
            head_q <= head_q + IW'(ret_n_c);
            tail_q <= tail_q + IW'(alloc_n_c);
            cnt_q  <= RBW'(int'(cnt_q) + alloc_n_c - ret_n_c);
            used_q <= RBW'(int'(used_q) + alloc_u_c - ret_u_c);
        end
    end

    assign tail = tail_q;
    assign used = used_q;

    AST_ROB_BOUND: assert property (@(posedge clk) disable iff (rst)
        int'(used_q) <= ROBS); // R3
    AST_GROUP_WIDTH: assert property (@(posedge clk) disable iff (rst)
        alloc_u_c <= DW); // R2
    AST_RETIRE_LIMIT: assert property (@(posedge clk) disable iff (rst)
        (int'(ret_cnt) <= RW) && (int'(ret_cnt) <= int'(cnt_q))); // R8
    AST_WB_LIVE: assert property (@(posedge clk) disable iff (rst)
        wb_valid |-> (int'(IW'(wb_tag - head_q)) < int'(cnt_q))); // R8

endmodule

// File: rtl/dr_sched_credit.sv
module dr_sched_credit import dr_pkg::*; #(
    parameter int DW  = 2,
    parameter int NS  = 2,
    parameter int SQD = 4,
    localparam int UW  = bits_for(DW + 1),
    localparam int QBW = bits_for(SQD + 1)
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NS-1:0][UW-1:0]  add,
    input  logic [NS-1:0]          issue,
    output logic [NS-1:0][QBW-1:0] occ
);

    generate
        for (genvar s = 0; s < NS; s++) begin : g_q
            logic [QBW-1:0] occ_q;
            always_ff @(posedge clk) begin
                if (rst) occ_q <= '0;
                else     occ_q <= QBW'(int'(occ_q) + int'(add[s])
                                       - ((issue[s] && (occ_q != '0)) ? 1 : 0));
            end
            assign occ[s] = occ_q;

            AST_SCHED_BOUND: assert property (@(posedge clk) disable iff (rst)
                int'(occ_q) <= SQD); // R5
        end
    endgenerate

endmodule

// File: rtl/dr_stats.sv
module dr_stats import dr_pkg::*; #(
    parameter int DW = 2,
    parameter int RW = 2,
    parameter int CW = 16,
    localparam int UW  = bits_for(DW + 1),
    localparam int RCW = bits_for(RW + 1)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  stall_cause_e                   cause,
    input  logic [UW-1:0]                  disp_n,
    input  logic [RCW-1:0]                 ret_n,
    output logic [NUM_CAUSES-1:0][CW-1:0]  stall_cnt,
    output logic [DW:0][CW-1:0]            disp_hist,
    output logic [RW:0][CW-1:0]            ret_hist
);

    generate
        for (genvar c = 0; c < NUM_CAUSES; c++) begin : g_cause
            always_ff @(posedge clk) begin
                if (rst)                   stall_cnt[c] <= '0;
                else if (int'(cause) == c) stall_cnt[c] <= stall_cnt[c] + 1'b1;
            end
        end
        for (genvar h = 0; h <= DW; h++) begin : g_dh
            always_ff @(posedge clk) begin
                if (rst)                    disp_hist[h] <= '0;
                else if (int'(disp_n) == h) disp_hist[h] <= disp_hist[h] + 1'b1;
            end
        end
        for (genvar h = 0; h <= RW; h++) begin : g_rh
            always_ff @(posedge clk) begin
                if (rst)                   ret_hist[h] <= '0;
                else if (int'(ret_n) == h) ret_hist[h] <= ret_hist[h] + 1'b1;
            end
        end
    endgenerate

    AST_HIST_RANGE: assert property (@(posedge clk) disable iff (rst)
        (int'(disp_n) <= DW) && (int'(ret_n) <= RW)); // R11

endmodule

// File: rtl/dispatch_retire_ctrl.sv
module dispatch_retire_ctrl import dr_pkg::*; #(
    parameter int DISP_W      = 2,
    parameter int RET_W       = DISP_W,
    parameter int ROB_SLOTS   = 8,
    parameter int PREG_POOL   = 4,
    parameter int NUM_SCHED   = 2,
    parameter int SCHED_DEPTH = 4,
    parameter int CNT_W       = 16,
    localparam int UOP_W = bits_for(DISP_W + 1),
    localparam int SEL_W = bits_for(NUM_SCHED),
    localparam int TAG_W = bits_for(ROB_SLOTS),
    localparam int RBW   = bits_for(ROB_SLOTS + 1),
    localparam int PBW   = bits_for(PREG_POOL + 1),
    localparam int RCW   = bits_for(RET_W + 1),
    localparam int QBW   = bits_for(SCHED_DEPTH + 1)
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic [DISP_W-1:0]                 in_valid,
    input  logic [DISP_W-1:0][UOP_W-1:0]      in_uops,
    input  logic [DISP_W-1:0]                 in_dst,
    input  logic [DISP_W-1:0]                 in_ld,
    input  logic [DISP_W-1:0]                 in_st,
    input  logic [DISP_W-1:0][SEL_W-1:0]      in_sched,
    input  logic [NUM_SCHED-1:0]              sched_issue,
    input  logic                              lq_full,
    input  logic                              sq_full,
    input  logic                              wb_valid,
    input  logic [TAG_W-1:0]                  wb_tag,
    output logic [DISP_W-1:0]                 disp_valid,
    output logic [DISP_W-1:0][TAG_W-1:0]      disp_tag,
    output logic [RCW-1:0]                    ret_count,
    output logic [RBW-1:0]                    rob_used,
    output logic [PBW-1:0]                    free_regs,
    output logic [NUM_CAUSES-1:0][CNT_W-1:0]  stall_cnt,
    output logic [DISP_W:0][CNT_W-1:0]        disp_hist,
    output logic [RET_W:0][CNT_W-1:0]         ret_hist
);

    logic [DISP_W-1:0]                 take;
    logic [UOP_W-1:0]                  grp_dst;
    logic [NUM_SCHED-1:0][UOP_W-1:0]   sched_add;
    logic [NUM_SCHED-1:0][QBW-1:0]     sched_occ;
    logic [TAG_W-1:0]                  rob_tail;
    logic [RCW-1:0]                    ret_dst;
    logic [UOP_W-1:0]                  disp_uops;
    stall_cause_e                      cause;

    dr_group_sel #(.DW(DISP_W), .NS(NUM_SCHED), .SQD(SCHED_DEPTH),
                   .ROBS(ROB_SLOTS), .PRF(PREG_POOL)) u_sel (
        .clk(clk), .rst(rst),
        .in_valid(in_valid), .in_uops(in_uops), .in_dst(in_dst),
        .in_ld(in_ld), .in_st(in_st), .in_sched(in_sched),
        .lq_full(lq_full), .sq_full(sq_full),
        .rob_used(rob_used), .free_regs(free_regs), .sched_occ(sched_occ),
        .rob_tail(rob_tail),
        .take(take), .tag(disp_tag), .grp_dst(grp_dst),
        .sched_add(sched_add), .cause(cause)
    );

    dr_rob #(.DW(DISP_W), .RW(RET_W), .ROBS(ROB_SLOTS)) u_rob (
        .clk(clk), .rst(rst),
        .alloc(take), .alloc_uops(in_uops), .alloc_dst(in_dst),
        .wb_valid(wb_valid), .wb_tag(wb_tag),
        .tail(rob_tail), .used(rob_used),
        .ret_cnt(ret_count), .ret_dst(ret_dst)
    );

    dr_sched_credit #(.DW(DISP_W), .NS(NUM_SCHED), .SQD(SCHED_DEPTH)) u_sq (
        .clk(clk), .rst(rst),
        .add(sched_add), .issue(sched_issue), .occ(sched_occ)
    );

    always_comb begin
        int n;
        n = 0;
        for (int i = 0; i < DISP_W; i++) if (take[i]) n = n + int'(in_uops[i]);
        disp_uops = UOP_W'(n);
    end

    dr_stats #(.DW(DISP_W), .RW(RET_W), .CW(CNT_W)) u_stats (
        .clk(clk), .rst(rst), .cause(cause),
        .disp_n(disp_uops), .ret_n(ret_count),
        .stall_cnt(stall_cnt), .disp_hist(disp_hist), .ret_hist(ret_hist)
    );

    generate
        if (PREG_POOL > 0) begin : g_pool
            logic [PBW-1:0] free_q;
            always_ff @(posedge clk) begin
                if (rst) free_q <= PBW'(PREG_POOL);
                else     free_q <= PBW'(int'(free_q) + int'(ret_dst) - int'(grp_dst));
            end
            assign free_regs = free_q;

            AST_POOL_BOUND: assert property (@(posedge clk) disable iff (rst)
                int'(free_q) <= PREG_POOL); // R4
        end else begin : g_unlimited
            assign free_regs = '0;
        end
    endgenerate

    assign disp_valid = take;

endmodule

// File: tb/sim_dispatch_retire_ctrl.sv
`timescale 1ns/1ps
module sim_dispatch_retire_ctrl;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [1:0]       in_valid, in_dst, in_ld, in_st, sched_issue;
    logic [1:0][1:0]  in_uops;
    logic [1:0][0:0]  in_sched;
    logic             lq_full, sq_full, wb_valid;
    logic [2:0]       wb_tag;

    logic [1:0]        dv0, dv1;
    logic [1:0][2:0]   dt0, dt1;
    logic [1:0]        rc0, rc1;
    logic [3:0]        ru0, ru1;
    logic [2:0]        fr0;
    logic [0:0]        fr1;
    logic [4:0][15:0]  sc0, sc1;
    logic [2:0][15:0]  dh0, dh1, rh0, rh1;

    int checks = 0;
    int errors = 0;

    dispatch_retire_ctrl u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops), .in_dst(in_dst),
        .in_ld(in_ld), .in_st(in_st), .in_sched(in_sched), .sched_issue(sched_issue),
        .lq_full(lq_full), .sq_full(sq_full), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .disp_valid(dv0), .disp_tag(dt0), .ret_count(rc0), .rob_used(ru0),
        .free_regs(fr0), .stall_cnt(sc0), .disp_hist(dh0), .ret_hist(rh0));

    dispatch_retire_ctrl #(.PREG_POOL(0)) u1 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_uops(in_uops), .in_dst(in_dst),
        .in_ld(in_ld), .in_st(in_st), .in_sched(in_sched), .sched_issue(sched_issue),
        .lq_full(lq_full), .sq_full(sq_full), .wb_valid(wb_valid), .wb_tag(wb_tag),
        .disp_valid(dv1), .disp_tag(dt1), .ret_count(rc1), .rob_used(ru1),
        .free_regs(fr1), .stall_cnt(sc1), .disp_hist(dh1), .ret_hist(rh1));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr();
        in_valid = '0; in_dst = '0; in_ld = '0; in_st = '0;
        in_uops = '0; in_sched = '0;
    endtask

    task automatic put(input int s, input int u, input bit d, input bit ld,
                       input bit st, input int sc);
        in_valid[s] = 1'b1; in_uops[s] = 2'(u); in_dst[s] = d;
        in_ld[s] = ld; in_st[s] = st; in_sched[s] = 1'(sc);
    endtask

    task automatic do_reset();
        rst = 1'b1; clr();
        sched_issue = '0; lq_full = 1'b0; sq_full = 1'b0; wb_valid = 1'b0; wb_tag = '0;
        step(); step();
        rst = 1'b0;
    endtask

    task automatic wb(input int t);
        wb_valid = 1'b1; wb_tag = 3'(t);
        step();
        wb_valid = 1'b0;
    endtask

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clr(); sched_issue = '0; lq_full = 0; sq_full = 0; wb_valid = 0; wb_tag = '0;
        @(negedge clk);
        do_reset();
        // R12 reset state
        #1;
        chk("R12 rob_used", int'(ru0), 0);
        chk("R12 free_regs", int'(fr0), 4);
        chk("R12 disp_valid", int'(dv0), 0);
        chk("R12 ret_count", int'(rc0), 0);
        for (int c = 0; c < 5; c++) chk("R12 stall_cnt", int'(sc0[c]), 0);
        step(); step(); step();
        chk("R11 idle disp_hist", int'(dh0[0]), 3);
        chk("R11 idle ret_hist", int'(rh0[0]), 3);

        // R2 / R10: sweep of micro-op pairs on an empty buffer
        for (int u0v = 1; u0v <= 2; u0v++) begin
            for (int u1v = 1; u1v <= 2; u1v++) begin
                int both, tk;
                do_reset();
                put(0, u0v, 0, 0, 0, 0); put(1, u1v, 0, 0, 0, 1);
                both = (u0v + u1v <= 2);
                tk = both ? u0v + u1v : u0v;
                #1;
                chk("R2 group mask", int'(dv0), both ? 3 : 1);
                chk("R10 tag slot0", int'(dt0[0]), 0);
                if (both) chk("R10 tag slot1", int'(dt0[1]), 1);
                step(); clr();
                chk("R3 rob_used after group", int'(ru0), tk);
                chk("R11 disp_hist", int'(dh0[tk]), 1);
                chk("R7 width not a stall", int'(sc0[0] + sc0[1] + sc0[2] + sc0[3] + sc0[4]), 0);
            end
        end

        // R3 / R7 / R8 / R9: fill buffer with 2-uop instructions
        do_reset();
        for (int k = 0; k < 4; k++) begin
            clr(); put(0, 2, 0, 0, 0, k % 2);
            #1;
            chk("R10 sequential tag", int'(dt0[0]), k);
            chk("R2 single 2-uop", int'(dv0), 1);
            step();
        end
        clr();
        chk("R3 buffer full", int'(ru0), 8);
        put(0, 1, 0, 0, 0, 0);
        #1 chk("R3 stall when full", int'(dv0), 0);
        step(); clr();
        chk("R7 rob cause", int'(sc0[0]), 1);
        chk("R7 other causes", int'(sc0[1] + sc0[2] + sc0[3] + sc0[4]), 0);
        wb(1);
        #1 chk("R8 younger done waits", int'(rc0), 0);
        wb(0);
        #1 chk("R8 two retire in order", int'(rc0), 2);
        step();
        chk("R9 slots freed", int'(ru0), 4);
        chk("R11 ret_hist two", int'(rh0[2]), 1);

        // R4 / R9: register pool
        do_reset();
        chk("R12 rob reset after fill", int'(ru0), 0);
        put(0, 1, 1, 0, 0, 0); put(1, 1, 1, 0, 0, 1);
        #1 chk("R4 two regs", int'(dv0), 3);
        step();
        #1 chk("R4 two more regs", int'(dv0), 3);
        step(); clr();
        chk("R4 pool empty", int'(fr0), 0);
        put(0, 1, 1, 0, 0, 0);
        #1;
        chk("R4 stall without register", int'(dv0), 0);
        chk("R4 unlimited pool dispatches", int'(dv1), 1);
        step(); clr();
        chk("R7 register cause", int'(sc0[1]), 1);
        chk("R4 unlimited pool no stall", int'(sc1[1]), 0);
        wb(0);
        #1 chk("R8 retire one", int'(rc0), 1);
        step();
        chk("R9 register returned", int'(fr0), 1);
        put(0, 1, 1, 0, 0, 0);
        #1 chk("R9 dispatch after release", int'(dv0), 1);
        step(); clr();

        // R1 / R5 / R7: scheduler credits
        do_reset();
        for (int k = 0; k < 2; k++) begin
            clr(); put(0, 1, 0, 0, 0, 0); put(1, 1, 0, 0, 0, 0);
            #1 chk("R5 fill sched0", int'(dv0), 3);
            step();
        end
        clr(); put(0, 1, 0, 0, 0, 0); put(1, 1, 0, 0, 0, 1);
        #1 chk("R1 younger held behind full sched", int'(dv0), 0);
        step();
        chk("R7 sched cause", int'(sc0[2]), 1);
        lq_full = 1'b1; in_ld[0] = 1'b1;
        #1 chk("R7 load also blocked", int'(dv0), 0);
        step();
        chk("R7 sched beats load", int'(sc0[2]), 2);
        chk("R7 load not counted", int'(sc0[3]), 0);
        lq_full = 1'b0; in_ld[0] = 1'b0;
        sched_issue[0] = 1'b1;
        step();
        sched_issue = '0;
        #1 chk("R5 credit returned", int'(dv0), 3);
        step(); clr();
        sched_issue[0] = 1'b1;
        step();
        sched_issue = '0;
        put(0, 1, 0, 0, 0, 0); put(1, 1, 0, 0, 0, 0);
        #1 chk("R5 group counts same target", int'(dv0), 1);
        step(); clr();

        // R6: load and store queues
        do_reset();
        lq_full = 1'b1; put(0, 1, 0, 1, 0, 0);
        #1 chk("R6 load blocked", int'(dv0), 0);
        step(); clr();
        chk("R6 load cause", int'(sc0[3]), 1);
        put(0, 1, 0, 0, 0, 0);
        #1 chk("R6 non-load passes", int'(dv0), 1);
        step(); clr();
        lq_full = 1'b0; sq_full = 1'b1;
        put(0, 1, 0, 0, 1, 1);
        #1 chk("R6 store blocked", int'(dv0), 0);
        step(); clr();
        chk("R6 store cause", int'(sc0[4]), 1);
        sq_full = 1'b0;

        // R8 / R9 / R11: retire width cap
        do_reset();
        for (int k = 0; k < 2; k++) begin
            clr(); put(0, 1, 0, 0, 0, 0); put(1, 1, 0, 0, 0, 1);
            step();
        end
        clr();
        chk("R11 disp_hist two", int'(dh0[2]), 2);
        wb(3); wb(2); wb(1);
        #1 chk("R8 head not done", int'(rc0), 0);
        wb(0);
        #1 chk("R8 capped at width", int'(rc0), 2);
        step();
        #1 chk("R8 remaining pair", int'(rc0), 2);
        step();
        chk("R9 buffer drained", int'(ru0), 0);
        chk("R11 ret_hist two", int'(rh0[2]), 2);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule